// File: doc/BRIEF.md
# Prime-Modulus Word Shift Register with Output Reorganization

This block is the state register of a word-oriented stream cipher: sixteen stages of 31 bits each, updated by a feedback word that is a sum modulo the prime 2^31-1 of rotated stage values. The surrounding cipher controls it with three strobes. One loads the stages from a 128-bit key and a 128-bit IV, interleaved with fixed 15-bit constants. One advances the register in initialization mode, where an external 31-bit word joins the sum. One advances it in work mode, where only the stage terms are summed.

Four 32-bit words made from halves of selected stages are presented continuously. The nonlinear function reads three of them and the keystream combiner reads the fourth. The whole feedback sum completes within one clock, so a step can be taken on every cycle.

Top module: `mlfsr_core`

## Requirements
- R1: A clock edge with `rst_n` low clears every stage to zero, so all four outputs read 0x00000000.
- R2: When `load_en` is high at a clock edge, stage i (i = 0..15) becomes {key byte i, C_i, IV byte i}. The key byte is in bits 30..23, the 15-bit constant C_i in bits 22..8 and the IV byte in bits 7..0. Byte i is bits 127-8i down to 120-8i of its input, so byte 0 is the most significant. C_0..C_15 = 0x44D7, 0x26BC, 0x626B, 0x135E, 0x5789, 0x35E2, 0x7135, 0x09AF, 0x4D78, 0x2F13, 0x6BC4, 0x1AF1, 0x5E26, 0x3C4D, 0x789A, 0x47AC. An all-ones load gives stage 0 = 0x7FC4D7FF.
- R3: In a work-mode step the new word is the sum modulo 2^31-1 of six terms: stage 15 rotated left by 15, stage 13 by 17, stage 10 by 21, stage 4 by 20, stage 0 by 8, and stage 0 unrotated. Every rotation is within 31 bits. Each two-input addition wraps its carry out of bit 31 back into bit 0.
- R4: In an initialization-mode step the 31-bit input `u_in` is a seventh term of the same modular sum.
- R5: A new word whose value is congruent to zero is written as 0x7FFFFFFF, in either mode.
- R6: Each step drops stage 0, moves stage i+1 into stage i for i = 0..14, and writes the new word into stage 15.
- R7: Outputs are built from hi(s) = bits 30..15 and lo(s) = bits 15..0 of a stage: x0 = {hi(s15), lo(s14)}, x1 = {lo(s11), hi(s9)}, x2 = {lo(s7), hi(s5)}, x3 = {lo(s2), hi(s0)}. They are combinational from the current stages.
- R8: Priority is load over initialization step over work step when strobes coincide.
- R9: With no strobe high, the stages keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Load stages from key and IV |
| init_en | input | 1 | Initialization-mode step |
| work_en | input | 1 | Work-mode step |
| key_in | input | 128 | Key, byte 0 in the top bits |
| iv_in | input | 128 | IV, byte 0 in the top bits |
| u_in | input | 31 | Extra feedback term for initialization steps |
| x0 | output | 32 | {hi(s15), lo(s14)} |
| x1 | output | 32 | {lo(s11), hi(s9)} |
| x2 | output | 32 | {lo(s7), hi(s5)} |
| x3 | output | 32 | {lo(s2), hi(s0)} |

## Verification
Loads are tried with all-zero, all-ones and two mixed key/IV pairs. Zero and all-ones isolate the constants from the data bytes, and the mixed pairs expose any byte-order or field-position swap. Each load is followed by initialization steps with varied `u_in` and then work steps, compared against an independent model. This separates the unrotated s0 term, the tap rotations, the end-around carry and the u term. Starting from the all-zero reset state, both modes drive the sum to zero, which isolates the 0x7FFFFFFF substitution. Coinciding strobes and idle cycles expose priority and hold errors.

// File: rtl/mlfsr_pkg.sv
// Package: shared widths, state type and load constants for the
// prime-modulus shift register. Assumes 16 stages of 31 bits.
package mlfsr_pkg;
    localparam int WORD_W  = 31;
    localparam int NSTAGE  = 16;
    localparam int CONST_W = 15;
    localparam int BYTE_W  = 8;
    localparam int OUT_W   = 32;
    localparam int HALF_W  = OUT_W / 2;

    typedef logic [WORD_W-1:0]             word_t;
    typedef logic [NSTAGE-1:0][WORD_W-1:0] state_t;

    // Per-stage 15-bit constant placed between key and IV bytes
    function automatic logic [CONST_W-1:0] load_const(input int idx);
        logic [CONST_W-1:0] c;
        case (idx)
            0:  c = 15'h44D7;
            1:  c = 15'h26BC;
            2:  c = 15'h626B;
            3:  c = 15'h135E;
            4:  c = 15'h5789;
            5:  c = 15'h35E2;
            6:  c = 15'h7135;
            7:  c = 15'h09AF;
            8:  c = 15'h4D78;
            9:  c = 15'h2F13;
            10: c = 15'h6BC4;
            11: c = 15'h1AF1;
            12: c = 15'h5E26;
            13: c = 15'h3C4D;
            14: c = 15'h789A;
            default: c = 15'h47AC;
        endcase
        return c;
    endfunction

    // Left rotation within one word
    function automatic word_t rotl(input word_t x, input int n);
        return (n == 0) ? x : word_t'((x << n) | (x >> (WORD_W - n)));
    endfunction
endpackage

// File: rtl/mlfsr_madd.sv
// Module: two-input adder modulo 2^WORD_W-1 with end-around carry.
// Assumes both operands are WORD_W bits; 2^WORD_W-1 may represent zero.
module mlfsr_madd
    import mlfsr_pkg::*;
(
    input  word_t a_i,
    input  word_t b_i,
    output word_t s_o
);
    logic [WORD_W:0] raw;

    // Full-width sum, then fold the carry back into bit 0
    always_comb begin
        raw = {1'b0, a_i} + {1'b0, b_i};
        s_o = raw[WORD_W] ? word_t'(raw[WORD_W-1:0] + 1'b1) : raw[WORD_W-1:0];
    end

    // R3: a zero result can only come from two zero operands
    always_comb begin
        if (!$isunknown({a_i, b_i}))
            a_r3_zero_only_from_zeros: assert (s_o != '0 || (a_i == '0 && b_i == '0));
    end
endmodule

// File: rtl/mlfsr_feedback.sv
// Module: computes the next stage-15 word as a modular sum of rotated
// taps plus an optional external term, with zero forced to all ones.
// Assumes one-cycle combinational evaluation.
module mlfsr_feedback
    import mlfsr_pkg::*;
(
    input  state_t st_i,
    input  logic   use_u_i,
    input  word_t  u_i,
    output word_t  new_o
);
    localparam int NTAP = 6;
    localparam int TAP_IDX [NTAP] = '{15, 13, 10, 4, 0, 0};
    localparam int TAP_ROT [NTAP] = '{15, 17, 21, 20, 8, 0};

    word_t term [NTAP+1];
    word_t lv1  [3];
    word_t lv2  [2];
    word_t total;

    // Rotated tap terms
    for (genvar t = 0; t < NTAP; t++) begin : g_tap
        assign term[t] = rotl(st_i[TAP_IDX[t]], TAP_ROT[t]);
    end
    // External term only in initialization mode
    assign term[NTAP] = use_u_i ? u_i : '0;

    // Adder tree: 7 terms in three levels
    for (genvar p = 0; p < 3; p++) begin : g_lv1
        mlfsr_madd u_add (.a_i(term[2*p]), .b_i(term[2*p+1]), .s_o(lv1[p]));
    end
    mlfsr_madd u_add20 (.a_i(lv1[0]), .b_i(lv1[1]),     .s_o(lv2[0]));
    mlfsr_madd u_add21 (.a_i(lv1[2]), .b_i(term[NTAP]), .s_o(lv2[1]));
    mlfsr_madd u_add3  (.a_i(lv2[0]), .b_i(lv2[1]),     .s_o(total));

    // Zero substitution
    assign new_o = (total == '0) ? '1 : total;

    // R5: the written word is never zero
    always_comb begin
        if (!$isunknown(new_o))
            a_r5_never_zero: assert (new_o != '0);
    end
endmodule

// File: rtl/mlfsr_reorg.sv
// Module: forms four 32-bit words from half-words of selected stages.
// Assumes hi = bits 30..15 and lo = bits 15..0 of a stage.
module mlfsr_reorg
    import mlfsr_pkg::*;
(
    input  state_t            st_i,
    output logic [OUT_W-1:0]  x0_o,
    output logic [OUT_W-1:0]  x1_o,
    output logic [OUT_W-1:0]  x2_o,
    output logic [OUT_W-1:0]  x3_o
);
    function automatic logic [HALF_W-1:0] hi(input word_t w);
        return w[WORD_W-1 -: HALF_W];
    endfunction
    function automatic logic [HALF_W-1:0] lo(input word_t w);
        return w[HALF_W-1:0];
    endfunction

    // Pure wiring of stage halves
    always_comb begin
        x0_o = {hi(st_i[15]), lo(st_i[14])};
        x1_o = {lo(st_i[11]), hi(st_i[9])};
        x2_o = {lo(st_i[7]),  hi(st_i[5])};
        x3_o = {lo(st_i[2]),  hi(st_i[0])};
    end
endmodule

// File: rtl/mlfsr_core.sv
// Module: top of the prime-modulus shift register. Holds the stages,
// loads them from key/IV, steps in either mode, and drives the
// reorganized outputs. Assumes priority load > init > work.
module mlfsr_core
    import mlfsr_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic         init_en,
    input  logic         work_en,
    input  logic [127:0] key_in,
    input  logic [127:0] iv_in,
    input  logic [30:0]  u_in,
    output logic [31:0]  x0,
    output logic [31:0]  x1,
    output logic [31:0]  x2,
    output logic [31:0]  x3
);
    state_t st;
    state_t ld_val;
    word_t  fb_word;

    // Load image: key byte, constant, IV byte per stage
    for (genvar i = 0; i < NSTAGE; i++) begin : g_ld
        assign ld_val[i] = {key_in[127-BYTE_W*i -: BYTE_W], load_const(i),
                            iv_in[127-BYTE_W*i -: BYTE_W]};
    end

    mlfsr_feedback u_fb (
        .st_i    (st),
        .use_u_i (init_en),
        .u_i     (u_in),
        .new_o   (fb_word)
    );

    mlfsr_reorg u_rg (
        .st_i (st),
        .x0_o (x0),
        .x1_o (x1),
        .x2_o (x2),
        .x3_o (x3)
    );

    // Stage register: reset, load, or shift in the feedback word
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= '0;
        else if (load_en)
            st <= ld_val;
        else if (init_en || work_en)
            st <= {fb_word, st[NSTAGE-1:1]};
    end

    // R6: a step moves stage 1 into stage 0
    a_r6_shift_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && (init_en || work_en)) |=> st[0] == $past(st[1]));

    // R9: idle cycles leave the stages unchanged
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !init_en && !work_en) |=> $stable(st));

    // R2: stage 0 after a load carries key byte 0 and IV byte 0
    a_r2_load_edges: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (st[0][30:23] == $past(key_in[127:120]) &&
                     st[0][7:0]   == $past(iv_in[127:120])));

    // R8: load wins over a simultaneous step
    a_r8_load_first: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && (init_en || work_en)) |=>
            st[15][7:0] == $past(iv_in[7:0]));
endmodule

// File: tb/sim_mlfsr_core.sv
`timescale 1ns/1ps
module sim_mlfsr_core;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_en = 1'b0, init_en = 1'b0, work_en = 1'b0;
    logic [127:0] key_in = '0, iv_in = '0;
    logic [30:0]  u_in = '0;
    logic [31:0]  x0, x1, x2, x3;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0][30:0] m;

    always #2 clk = ~clk;

    mlfsr_core u0 (.clk(clk), .rst_n(rst_n), .load_en(load_en), .init_en(init_en),
                   .work_en(work_en), .key_in(key_in), .iv_in(iv_in), .u_in(u_in),
                   .x0(x0), .x1(x1), .x2(x2), .x3(x3));

    localparam logic [14:0] CK [16] = '{15'h44D7, 15'h26BC, 15'h626B, 15'h135E,
        15'h5789, 15'h35E2, 15'h7135, 15'h09AF, 15'h4D78, 15'h2F13, 15'h6BC4,
        15'h1AF1, 15'h5E26, 15'h3C4D, 15'h789A, 15'h47AC};

    localparam int NV = 4;
    localparam logic [255:0] VEC [NV] = '{
        {128'h0, 128'h0},
        {{128{1'b1}}, {128{1'b1}}},
        {128'h3d4c4be96a82fdaeb58f641db17b455b, 128'h84319aa8de6915ca1f6bda6bfbd8c766},
        {128'h4d320bfad4c285bfd6b8bd00f39d8b41, 128'h52959daba0bf176ece2dc315049eb574}};

    function automatic logic [30:0] brot(input logic [30:0] x, input int n);
        longint unsigned v;
        v = ((longint'(x) << n) | (longint'(x) >> (31 - n))) & 64'h7FFFFFFF;
        return v[30:0];
    endfunction

    function automatic logic [30:0] mnext(input logic [15:0][30:0] s,
                                          input logic useu, input logic [30:0] u);
        longint unsigned acc;
        acc = longint'(brot(s[15], 15)) + longint'(brot(s[13], 17))
            + longint'(brot(s[10], 21)) + longint'(brot(s[4], 20))
            + longint'(brot(s[0], 8)) + longint'(s[0]) + (useu ? longint'(u) : 64'd0);
        acc = acc % 64'h7FFFFFFF;
        return (acc == 0) ? 31'h7FFFFFFF : acc[30:0];
    endfunction

    function automatic logic [31:0] mx(input logic [15:0][30:0] s, input int k);
        case (k)
            0: return {s[15][30:15], s[14][15:0]};
            1: return {s[11][15:0], s[9][30:15]};
            2: return {s[7][15:0], s[5][30:15]};
            default: return {s[2][15:0], s[0][30:15]};
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, x0, mx(m, 0));
        chk(req, x1, mx(m, 1));
        chk(req, x2, mx(m, 2));
        chk(req, x3, mx(m, 3));
    endtask

    task automatic mload(input logic [127:0] k, input logic [127:0] v);
        for (int i = 0; i < 16; i++)
            m[i] = {k[127-8*i -: 8], CK[i], v[127-8*i -: 8]};
    endtask

    // One cycle with the given strobes; model follows R8 priority
    task automatic cyc(input logic l, input logic in, input logic w);
        @(negedge clk);
        load_en = l; init_en = in; work_en = w;
        @(negedge clk);
        load_en = 0; init_en = 0; work_en = 0;
        if (l) mload(key_in, iv_in);
        else if (in || w) m = {mnext(m, in, u_in), m[15:1]};
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        m = '0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1", x0, 32'h0); chk("R1", x1, 32'h0);
        chk("R1", x2, 32'h0); chk("R1", x3, 32'h0);

        // Table walk: load, init steps, work steps (R2 R3 R4 R6 R7)
        for (int v = 0; v < NV; v++) begin
            key_in = VEC[v][255:128];
            iv_in  = VEC[v][127:0];
            cyc(1, 0, 0);
            chk_all("R2");
            for (int t = 0; t < 10; t++) begin
                u_in = (t == 0) ? 31'h0 : 31'(32'h9E3779B9 * (v + 1) + 32'(t) * 32'h01234567);
                cyc(0, 1, 0);
                chk_all("R4");
            end
            for (int t = 0; t < 20; t++) begin
                u_in = 31'h5A5A5A5A;
                cyc(0, 0, 1);
                chk_all("R3");
            end
        end

        // R2: all-ones load gives stage 0 = 0x7FC4D7FF, hi half 0xFF89
        key_in = '1; iv_in = '1;
        cyc(1, 0, 0);
        chk("R2", {16'h0, x3[15:0]}, 32'h0000FF89);
        // R2: all-zero load, stage 15 = 0x0047AC00 and stage 14 = 0x00789A00
        key_in = '0; iv_in = '0;
        cyc(1, 0, 0);
        chk("R2", x0, 32'h008F9A00);

        // R5: work step from all-zero state forces all ones into stage 15
        do_reset();
        chk("R1", x0, 32'h0);
        cyc(0, 0, 1);
        chk("R5", x0, 32'hFFFF0000);
        // R6: the forced word then moves down into stage 14
        cyc(0, 0, 1);
        chk("R6", x0, mx(m, 0));
        // R5: init step with u = 0x7FFFFFFF from zero state
        do_reset();
        u_in = 31'h7FFFFFFF;
        cyc(0, 1, 0);
        chk("R5", x0, 32'hFFFF0000);

        // R8: load with steps wins
        key_in = VEC[2][255:128]; iv_in = VEC[2][127:0];
        cyc(1, 1, 1);
        chk_all("R8");
        // R8: init beats work (u term present)
        u_in = 31'h12345678;
        cyc(0, 1, 1);
        chk_all("R8");

        // R9: idle cycles hold
        repeat (3) cyc(0, 0, 0);
        chk_all("R9");

        // R7: outputs follow state without an extra cycle
        cyc(0, 0, 1);
        chk("R7", x0, mx(m, 0));

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule